// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address stream for one burst access to a two-bank synchronous graphics DRAM whose rows hold 256 columns of 32-bit words. A controller presents a read, write or burst-stop command together with the bank, the start column, an auto-precharge flag and the current mode settings. Starting on the next cycle, the block emits one column per clock, marks each beat as valid, and flags the last beat of a finite burst with a one-cycle end pulse. When the command asked for auto precharge, it also raises a precharge request for the bank on that last beat.

The block samples the mode settings when it accepts each command. These settings are the burst length, linear or interleaved ordering, and a flag that forces every write to a single beat while reads keep the programmed length. A new read or write arriving during a burst replaces that burst on the next cycle. A stop command ends the burst at once. A full-page burst wraps around the row and runs until another command arrives. The block has no data path.

Top module: `burst_col_seq`

## Requirements
- R1: A read (cmd_type 0) or write (cmd_type 1) accepted with cmd_vld in cycle N gives its first beat in cycle N+1. That beat has beat_vld high, col_out equal to the start column, bank_out equal to the command bank and beat_wr equal to 1 for a write.
- R2: mode_bl selects the burst length: 0→1, 1→2, 2→4 and 3→8 beats, and any other value selects a full page. A full page advances the column by one modulo 256 each cycle, never ends by itself and never pulses burst_end.
- R3: With mode_il low, beat i of a burst of length L sets the low log2(L) column bits to (start + i) mod L. The upper bits stay those of the start column.
- R4: With mode_il high and a finite length L, beat i sets the low log2(L) column bits to the start's low bits XOR i. With mode_il high and a full page, the order is linear.
- R5: With mode_brsw high, a write burst is exactly one beat long. A read burst keeps the length from mode_bl.
- R6: A read or write accepted while a burst is active starts the new burst on the next cycle at its own column. The remaining beats of the old burst are dropped, and the old burst gives neither burst_end nor pre_req.
- R7: A burst stop (cmd_type 2) leaves beat_vld low from the next cycle on, with no burst_end and no pre_req.
- R8: burst_end is high for exactly one cycle, on the last beat of a finite burst that runs to completion. In that cycle beat_vld is high, and with no new command beat_vld is low in the following cycle.
- R9: pre_req is high exactly in the burst_end cycle of a burst whose command had cmd_ap set. During that cycle bank_out names the bank to precharge.
- R10: While rst_n is low and after its release, beat_vld, burst_end and pre_req are low until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_type | input | 2 | 0 read, 1 write, 2 burst stop |
| cmd_bank | input | BANK_W | Bank of the access |
| cmd_col | input | COL_W | Start column |
| cmd_ap | input | 1 | Request auto precharge at the end of the burst |
| mode_bl | input | 3 | Burst length code |
| mode_il | input | 1 | 1 selects interleaved ordering |
| mode_brsw | input | 1 | 1 forces write bursts to a single beat |
| beat_vld | output | 1 | A beat is presented this cycle |
| beat_wr | output | 1 | The current beat belongs to a write |
| bank_out | output | BANK_W | Bank of the current burst |
| col_out | output | COL_W | Column of the current beat |
| burst_end | output | 1 | Last beat of a completed burst |
| pre_req | output | 1 | Auto-precharge request for bank_out |

## Verification
On every cycle the assertions check several properties. The first beat lands on the commanded column one cycle after acceptance. A stop empties the pipe. A single-write burst ends on its first beat. The end pulse and the precharge request appear only on a valid beat, and are followed by silence when no command arrives. The full column ordering for each length, ordering mode and start offset needs the bench's reference model. The same holds for full-page wrap past column 255, the dropping of beats after an interrupt, and the absence of end and precharge pulses for interrupted bursts. The bench compares all of these cycle by cycle over sweeps and directed sequences.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_WR   = 2'd1,
        CMD_STOP = 2'd2,
        CMD_NONE = 2'd3
    } cmd_e;

    // number of burst length codes that select a finite power-of-two length
    localparam int unsigned FINITE_CODES = 4;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
    import bcs_pkg::*;
#(
    parameter int COL_W = 8,
    localparam int KW = $clog2(COL_W + 1)
) (
    input  logic [2:0]    bl_code,
    input  logic          is_wr,
    input  logic          brsw,
    output logic [KW-1:0] len_log2,
    output logic          full_page
);
    always_comb begin
        if (is_wr && brsw) begin
            len_log2  = '0;
            full_page = 1'b0;
        end else if (32'(bl_code) < FINITE_CODES) begin
            len_log2  = KW'(bl_code);
            full_page = 1'b0;
        end else begin
            len_log2  = KW'(COL_W);
            full_page = 1'b1;
        end
    end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
    parameter int COL_W = 8,
    localparam int KW = $clog2(COL_W + 1)
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [KW-1:0]    len_log2,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] lin_sum;
    assign lin_sum = start_col + beat_idx;

    for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
        logic in_blk;
        assign in_blk  = (KW'(gi) < len_log2);
        assign col[gi] = !in_blk ? start_col[gi]
                       : (ilv ? (start_col[gi] ^ beat_idx[gi]) : lin_sum[gi]);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [1:0]        cmd_type,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic [2:0]        mode_bl,
    input  logic              mode_il,
    input  logic              mode_brsw,
    output logic              beat_vld,
    output logic              beat_wr,
    output logic [BANK_W-1:0] bank_out,
    output logic [COL_W-1:0]  col_out,
    output logic              burst_end,
    output logic              pre_req
);
    localparam int KW = $clog2(COL_W + 1);

    typedef struct packed {
        logic              active;
        logic              wr;
        logic              ap;
        logic              ilv;
        logic              full;
        logic [KW-1:0]     len_log2;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  cnt;
    } seq_t;

    seq_t st_q, st_d;

    logic [KW-1:0]    new_log2;
    logic             new_full;
    logic [COL_W:0]   len_sh;
    logic [COL_W-1:0] last_cnt;
    logic             at_last;
    cmd_e             ctype;

    assign ctype = cmd_e'(cmd_type);

    bcs_len_dec #(.COL_W(COL_W)) u_len (
        .bl_code  (mode_bl),
        .is_wr    (ctype == CMD_WR),
        .brsw     (mode_brsw),
        .len_log2 (new_log2),
        .full_page(new_full)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_col (
        .start_col(st_q.start),
        .beat_idx (st_q.cnt),
        .len_log2 (st_q.len_log2),
        .ilv      (st_q.ilv),
        .col      (col_out)
    );

    assign len_sh   = (COL_W + 1)'(1) << st_q.len_log2;
    assign last_cnt = len_sh[COL_W-1:0] - COL_W'(1);
    assign at_last  = st_q.active && !st_q.full && (st_q.cnt == last_cnt);

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (at_last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + COL_W'(1);
            end
        end
        if (cmd_vld) begin
            case (ctype)
                CMD_STOP: st_d.active = 1'b0;
                CMD_RD, CMD_WR: begin
                    st_d.active   = 1'b1;
                    st_d.wr       = (ctype == CMD_WR);
                    st_d.ap       = cmd_ap;
                    st_d.ilv      = mode_il && !new_full;
                    st_d.full     = new_full;
                    st_d.len_log2 = new_log2;
                    st_d.bank     = cmd_bank;
                    st_d.start    = cmd_col;
                    st_d.cnt      = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_vld  = st_q.active;
    assign beat_wr   = st_q.wr;
    assign bank_out  = st_q.bank;
    assign burst_end = at_last;
    assign pre_req   = at_last && st_q.ap;

    // R1
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && (cmd_type == 2'd0 || cmd_type == 2'd1))
        |=> (beat_vld && col_out == $past(cmd_col) && bank_out == $past(cmd_bank)));

    // R7
    stop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_type == 2'd2) |=> (!beat_vld && !burst_end && !pre_req));

    // R5
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_type == 2'd1 && mode_brsw) |=> (burst_end && beat_wr));

    // R8
    end_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> beat_vld);

    // R8
    end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end && !cmd_vld) |=> (!beat_vld && !burst_end));

    // R9
    pre_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> burst_end);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!beat_vld && !burst_end && !pre_req));
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld = 1'b0;
    logic [1:0] cmd_type = 2'd3;
    logic [0:0] cmd_bank = 1'b0;
    logic [7:0] cmd_col = 8'd0;
    logic       cmd_ap = 1'b0;
    logic [2:0] mode_bl = 3'd0;
    logic       mode_il = 1'b0;
    logic       mode_brsw = 1'b0;
    logic       beat_vld, beat_wr, burst_end, pre_req;
    logic [0:0] bank_out;
    logic [7:0] col_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 1'b0;
    bit done    = 1'b0;
    string cur_req = "R3";

    // reference state
    bit m_act = 0, m_wr = 0, m_ap = 0, m_il = 0;
    int m_bank = 0, m_start = 0, m_cnt = 0, m_len = 1;

    always #5 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .mode_bl(mode_bl), .mode_il(mode_il), .mode_brsw(mode_brsw),
        .beat_vld(beat_vld), .beat_wr(beat_wr), .bank_out(bank_out),
        .col_out(col_out), .burst_end(burst_end), .pre_req(pre_req)
    );

    function automatic int exp_col(int s, int c, int len, bit il);
        int off  = s % len;
        int base = s - off;
        if (il) return base + (off ^ c);
        return base + ((off + c) % len);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0;
        end else begin
            if (m_act) begin
                if (m_len != 256 && m_cnt == m_len - 1) m_act = 0;
                else m_cnt = (m_cnt + 1) % 256;
            end
            if (cmd_vld) begin
                if (cmd_type == 2'd2) m_act = 0;
                else if (cmd_type < 2'd2) begin
                    m_act   = 1;
                    m_wr    = (cmd_type == 2'd1);
                    m_ap    = cmd_ap;
                    m_bank  = int'(cmd_bank);
                    m_start = int'(cmd_col);
                    m_cnt   = 0;
                    m_len   = (mode_bl < 3'd4) ? (1 << mode_bl) : 256;
                    if (m_wr && mode_brsw) m_len = 1;
                    m_il    = mode_il && (m_len != 256);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            bit e_end;
            e_end = m_act && m_len != 256 && m_cnt == m_len - 1;
            chk(beat_vld == m_act, cur_req, "beat_vld", int'(beat_vld), int'(m_act));
            if (m_act) begin
                chk(int'(col_out) == exp_col(m_start, m_cnt, m_len, m_il), cur_req,
                    "col_out", int'(col_out), exp_col(m_start, m_cnt, m_len, m_il));
                chk(beat_wr == m_wr, "R1", "beat_wr", int'(beat_wr), int'(m_wr));
                chk(int'(bank_out) == m_bank, "R9", "bank_out", int'(bank_out), m_bank);
            end
            chk(burst_end == e_end, "R8", "burst_end", int'(burst_end), int'(e_end));
            chk(pre_req == (e_end && m_ap), "R9", "pre_req", int'(pre_req), int'(e_end && m_ap));
        end
    end

    task automatic issue(int t, int b, int c, bit ap, int bl, bit il, bit brsw);
        cmd_vld   = 1'b1;
        cmd_type  = 2'(t);
        cmd_bank  = 1'(b);
        cmd_col   = 8'(c);
        cmd_ap    = ap;
        mode_bl   = 3'(bl);
        mode_il   = il;
        mode_brsw = brsw;
        @(negedge clk);
        cmd_vld   = 1'b0;
        cmd_type  = 2'd3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs idle during reset
        chk(!beat_vld && !burst_end && !pre_req, "R10", "idle in reset",
            int'(beat_vld) + int'(burst_end) + int'(pre_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_vld && !burst_end && !pre_req, "R10", "idle after reset",
            int'(beat_vld) + int'(burst_end) + int'(pre_req), 0);
        running = 1'b1;

        // R3 / R4: sweep lengths, orderings, directions and offsets
        for (int il = 0; il < 2; il++) begin
            cur_req = (il == 1) ? "R4" : "R3";
            for (int bl = 0; bl < 4; bl++) begin
                for (int t = 0; t < 2; t++) begin
                    for (int s = 0; s < 10; s++) begin
                        int c;
                        c = (s < 8) ? s : ((s == 8) ? 13 : 250);
                        issue(t, s % 2, c, 1'b0, bl, il[0], 1'b0);
                        repeat ((1 << bl) + 1) @(negedge clk);
                    end
                end
            end
        end

        // R1: first beat lands on the commanded column
        cur_req = "R1";
        issue(0, 1, 77, 1'b0, 2, 1'b0, 1'b0);
        chk(beat_vld && col_out == 8'd77, "R1", "first beat col", int'(col_out), 77);
        repeat (5) @(negedge clk);

        // R2 / R4: full page, interleave flag ignored, wraps past 255
        cur_req = "R2";
        issue(0, 0, 250, 1'b1, 7, 1'b1, 1'b0);
        repeat (300) @(negedge clk);
        chk(beat_vld && !burst_end, "R2", "full page still running",
            int'(beat_vld), 1);
        issue(2, 0, 0, 1'b0, 0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // R5: single-beat writes, reads keep programmed length
        cur_req = "R5";
        issue(1, 0, 21, 1'b1, 3, 1'b0, 1'b1);
        chk(burst_end == 1'b1, "R5", "write single beat end", int'(burst_end), 1);
        repeat (3) @(negedge clk);
        issue(0, 1, 21, 1'b0, 3, 1'b1, 1'b1);
        repeat (10) @(negedge clk);

        // R6: write interrupted by write, then by read
        cur_req = "R6";
        issue(1, 0, 0, 1'b1, 3, 1'b0, 1'b0);
        @(negedge clk);
        issue(1, 1, 40, 1'b1, 3, 1'b0, 1'b0);
        chk(col_out == 8'd40 && beat_wr, "R6", "restart col", int'(col_out), 40);
        repeat (10) @(negedge clk);
        issue(1, 0, 8, 1'b1, 3, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        issue(0, 1, 16, 1'b0, 2, 1'b0, 1'b0);
        chk(!beat_wr && col_out == 8'd16, "R6", "read restart col", int'(col_out), 16);
        repeat (6) @(negedge clk);

        // R7: burst stop
        cur_req = "R7";
        issue(0, 0, 32, 1'b1, 3, 1'b0, 1'b0);
        @(negedge clk);
        issue(2, 0, 0, 1'b0, 3, 1'b0, 1'b0);
        chk(!beat_vld && !pre_req, "R7", "stopped", int'(beat_vld), 0);
        repeat (10) @(negedge clk);

        // R9: auto precharge on bank 1
        cur_req = "R9";
        issue(0, 1, 5, 1'b1, 2, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(pre_req && bank_out == 1'b1, "R9", "precharge bank", int'(pre_req), 1);
        repeat (4) @(negedge clk);

        running = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule